// File: doc/BRIEF.md
# Transfer Length and Data Timeout Tracker

This block follows the progress of one data transfer between a card host and a card. Before a transfer, software programs a total byte length, a block size code, a timeout in card clock periods, a mode (block or stream) and a direction. It then raises `xfer_en`. From then on the tracker counts the bytes that the serial data path accepts. It decides when each block is complete and waits for the CRC verdict of the block from the CRC engine. It raises one-cycle events for block completion, CRC failure, transfer completion and data timeout. The number of bytes still owed is always visible on `bytes_left`.

Bytes cross the boundary through a valid/ready handshake. The data path offers a byte with `byte_valid`, and the byte counts only in a cycle where `byte_ready` is also high. The tracker withholds `byte_ready` in four cases: while it waits for the card to start a block, while it waits for a CRC verdict, when the transfer is over, and when `xfer_en` is low. The data path must then hold its byte. The configuration inputs are sampled when the transfer starts and must stay stable until it ends. `card_tick` is a single-cycle strobe, one per card bus clock period. `card_go` marks a start bit or the end of busy signalling.

Top module: `xfer_len_tracker`

## Requirements
- R1: When `xfer_en` is raised while the tracker is idle, the next cycle shows `bytes_left` equal to `cfg_len` and `active` high, unless `cfg_len` is zero (see R6).
- R2: A block size code n from 0 to 14 selects 2^n bytes per block. Codes 15 and above behave as 14, which gives 16384 bytes.
- R3: `byte_ready` is high only while bytes are being moved. Each cycle with `byte_valid` and `byte_ready` both high lowers `bytes_left` by exactly one.
- R4: In block mode (`cfg_stream`=0), `byte_ready` drops after the last byte of a block or the last byte of the transfer, whichever comes first. The tracker then waits for `crc_valid`. A verdict with `crc_pass`=1 gives a one-cycle `blk_done` pulse.
- R5: A verdict with `crc_pass`=0 gives a one-cycle `crc_bad` pulse and ends the transfer. It produces no `blk_done` and no `data_done`, and `active` goes low.
- R6: `data_done` pulses for one cycle when `bytes_left` has reached zero. In block mode this happens together with the passing `blk_done` of the last block. In stream mode it happens in the cycle after the last byte. A zero length gives `data_done` in the cycle after the start.
- R7: In stream mode (`cfg_stream`=1), the bytes flow as one run with no CRC wait and no `blk_done`.
- R8: With `cfg_to_card`=0 (card to host), every block waits for `card_go` before `byte_ready` rises. With `cfg_to_card`=1 (host to card), the first block starts at once and each later block waits for `card_go`.
- R9: In each wait for `card_go` or for a CRC verdict, a timer is reloaded with `cfg_timeout` and counts down only on `card_tick`. The `cfg_timeout`-th tick ends the transfer with a one-cycle `data_tmo` pulse; when `cfg_timeout` is zero, the first tick does so. A `card_go` or `crc_valid` in the same cycle takes priority over the tick.
- R10: Lowering `xfer_en` aborts the transfer in the next cycle. No event is raised, `bytes_left` keeps its value, and no byte is accepted while `xfer_en` is low.
- R11: After reset, `bytes_left` is 0, and `active`, `byte_ready` and all four event outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_len | input | LEN_W | Total bytes to move |
| cfg_blk_code | input | 4 | Block size code, 2^n bytes |
| cfg_timeout | input | TO_W | Data timeout in card clock periods |
| cfg_stream | input | 1 | 1 = stream mode, 0 = block mode |
| cfg_to_card | input | 1 | 1 = host to card, 0 = card to host |
| xfer_en | input | 1 | Starts the transfer when raised, aborts it when lowered |
| byte_valid | input | 1 | Data path offers one byte |
| byte_ready | output | 1 | Tracker accepts the offered byte |
| card_tick | input | 1 | One pulse per card bus clock period |
| card_go | input | 1 | Start bit seen or busy released by the card |
| crc_valid | input | 1 | CRC verdict for the current block |
| crc_pass | input | 1 | Verdict value, 1 = CRC correct |
| bytes_left | output | LEN_W | Bytes still to be moved |
| active | output | 1 | A transfer is in progress |
| blk_done | output | 1 | Block finished with a good CRC (pulse) |
| crc_bad | output | 1 | Block CRC failed (pulse) |
| data_done | output | 1 | All bytes moved (pulse) |
| data_tmo | output | 1 | Data timeout (pulse) |

## Verification
The bench targets several corner cases:
- A transfer whose length is not a multiple of the block size. A design that counted only whole blocks would keep `byte_ready` high after the final byte or never ask for a CRC.
- Code 15 and the largest legal block. Wrong decoding would close the block early or late.
- The timer reload between blocks. A design that failed to reload it would time out too early in the second wait.
- A zero timeout, which must expire on the first tick.
- An abort in the middle of a block with the data path still offering bytes. A leaky handshake would keep lowering `bytes_left`.
- A failed CRC in a middle block. A wrong design would go on to later blocks or report completion.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int CODE_W   = 4;
  localparam int MAX_CODE = 14;
  localparam int BLK_W    = MAX_CODE + 1;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WAIT,
    PH_MOVE,
    PH_CRC,
    PH_DONE
  } phase_t;
endpackage

// File: rtl/xlt_blksize.sv
module xlt_blksize
  import xlt_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [BLK_W-1:0]  bytes
);
  // One-hot decode: bit g set means 2^g bytes; codes above the top clamp to it.
  for (genvar g = 0; g <= MAX_CODE; g++) begin : g_dec
    if (g == MAX_CODE) begin : g_top
      assign bytes[g] = (code >= CODE_W'(g));
    end else begin : g_mid
      assign bytes[g] = (code == CODE_W'(g));
    end
  end
endmodule

// File: rtl/xlt_timer.sv
module xlt_timer #(
  parameter int TO_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [TO_W-1:0] load_val,
  input  logic            run,
  input  logic            tick,
  output logic            expire
);
  logic [TO_W-1:0] cnt;

  // Expires on the tick that would take the count to zero (or at once when zero).
  assign expire = run && tick && (cnt <= TO_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (run && tick && (cnt != '0)) begin
      cnt <= cnt - TO_W'(1);
    end
  end
endmodule

// File: rtl/xlt_seq.sv
module xlt_seq
  import xlt_pkg::*;
#(
  parameter int LEN_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_en,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_stream,
  input  logic             cfg_to_card,
  input  logic [BLK_W-1:0] blk_bytes,
  input  logic             byte_valid,
  input  logic             card_go,
  input  logic             crc_valid,
  input  logic             crc_pass,
  input  logic             tmo_expire,
  output logic             byte_ready,
  output logic [LEN_W-1:0] bytes_left,
  output logic             active,
  output logic             blk_done,
  output logic             crc_bad,
  output logic             data_done,
  output logic             data_tmo,
  output logic             tmr_load,
  output logic             tmr_run
);
  phase_t           phase, phase_n;
  logic             stream_q;
  logic [BLK_W-1:0] blk_size_q;
  logic [BLK_W-1:0] blk_left;
  logic             start, accept;
  logic             blk_done_n, crc_bad_n, data_done_n, data_tmo_n;

  assign start      = (phase == PH_IDLE) && xfer_en;
  assign byte_ready = (phase == PH_MOVE) && xfer_en;
  assign accept     = byte_ready && byte_valid;
  assign active     = (phase == PH_WAIT) || (phase == PH_MOVE) || (phase == PH_CRC);
  assign tmr_run    = (phase == PH_WAIT) || (phase == PH_CRC);
  assign tmr_load   = ((phase_n == PH_WAIT) || (phase_n == PH_CRC)) && (phase_n != phase);

  always_comb begin
    phase_n     = phase;
    blk_done_n  = 1'b0;
    crc_bad_n   = 1'b0;
    data_done_n = 1'b0;
    data_tmo_n  = 1'b0;
    if (!xfer_en) begin
      phase_n = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (cfg_len == '0) begin
            phase_n     = PH_DONE;
            data_done_n = 1'b1;
          end else begin
            phase_n = cfg_to_card ? PH_MOVE : PH_WAIT;
          end
        end
        PH_WAIT: begin
          if (card_go) begin
            phase_n = PH_MOVE;
          end else if (tmo_expire) begin
            phase_n    = PH_DONE;
            data_tmo_n = 1'b1;
          end
        end
        PH_MOVE: begin
          if (accept) begin
            if (bytes_left == LEN_W'(1)) begin
              if (stream_q) begin
                phase_n     = PH_DONE;
                data_done_n = 1'b1;
              end else begin
                phase_n = PH_CRC;
              end
            end else if (!stream_q && (blk_left == BLK_W'(1))) begin
              phase_n = PH_CRC;
            end
          end
        end
        PH_CRC: begin
          if (crc_valid) begin
            if (crc_pass) begin
              blk_done_n = 1'b1;
              if (bytes_left == '0) begin
                phase_n     = PH_DONE;
                data_done_n = 1'b1;
              end else begin
                phase_n = PH_WAIT;
              end
            end else begin
              phase_n   = PH_DONE;
              crc_bad_n = 1'b1;
            end
          end else if (tmo_expire) begin
            phase_n    = PH_DONE;
            data_tmo_n = 1'b1;
          end
        end
        PH_DONE: phase_n = PH_DONE;
        default: phase_n = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      stream_q   <= 1'b0;
      blk_size_q <= '0;
      blk_left   <= '0;
      bytes_left <= '0;
      blk_done   <= 1'b0;
      crc_bad    <= 1'b0;
      data_done  <= 1'b0;
      data_tmo   <= 1'b0;
    end else begin
      phase     <= phase_n;
      blk_done  <= blk_done_n;
      crc_bad   <= crc_bad_n;
      data_done <= data_done_n;
      data_tmo  <= data_tmo_n;
      if (start) begin
        stream_q   <= cfg_stream;
        blk_size_q <= blk_bytes;
        bytes_left <= cfg_len;
      end else if (accept) begin
        bytes_left <= bytes_left - LEN_W'(1);
      end
      if ((phase_n == PH_MOVE) && (phase != PH_MOVE)) begin
        blk_left <= start ? blk_bytes : blk_size_q;
      end else if (accept) begin
        blk_left <= blk_left - BLK_W'(1);
      end
    end
  end
endmodule

// File: rtl/xfer_len_tracker.sv
module xfer_len_tracker
  import xlt_pkg::*;
#(
  parameter int LEN_W = 25,
  parameter int TO_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [CODE_W-1:0] cfg_blk_code,
  input  logic [TO_W-1:0]   cfg_timeout,
  input  logic              cfg_stream,
  input  logic              cfg_to_card,
  input  logic              xfer_en,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic              card_tick,
  input  logic              card_go,
  input  logic              crc_valid,
  input  logic              crc_pass,
  output logic [LEN_W-1:0]  bytes_left,
  output logic              active,
  output logic              blk_done,
  output logic              crc_bad,
  output logic              data_done,
  output logic              data_tmo
);
  logic [BLK_W-1:0] blk_bytes;
  logic             tmr_load, tmr_run, tmo_expire;

  xlt_blksize u_size (
    .code  (cfg_blk_code),
    .bytes (blk_bytes)
  );

  xlt_timer #(.TO_W(TO_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (cfg_timeout),
    .run      (tmr_run),
    .tick     (card_tick),
    .expire   (tmo_expire)
  );

  xlt_seq #(.LEN_W(LEN_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_en     (xfer_en),
    .cfg_len     (cfg_len),
    .cfg_stream  (cfg_stream),
    .cfg_to_card (cfg_to_card),
    .blk_bytes   (blk_bytes),
    .byte_valid  (byte_valid),
    .card_go     (card_go),
    .crc_valid   (crc_valid),
    .crc_pass    (crc_pass),
    .tmo_expire  (tmo_expire),
    .byte_ready  (byte_ready),
    .bytes_left  (bytes_left),
    .active      (active),
    .blk_done    (blk_done),
    .crc_bad     (crc_bad),
    .data_done   (data_done),
    .data_tmo    (data_tmo),
    .tmr_load    (tmr_load),
    .tmr_run     (tmr_run)
  );
endmodule

// File: rtl/xlt_chk.sv
module xlt_chk #(
  parameter int LEN_W = 25
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xfer_en,
  input logic             byte_valid,
  input logic             byte_ready,
  input logic [LEN_W-1:0] bytes_left,
  input logic             active,
  input logic             blk_done,
  input logic             crc_bad,
  input logic             data_done,
  input logic             data_tmo
);
  AST_READY_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> active); // R3
  AST_BYTE_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_ready) |=> (bytes_left == $past(bytes_left) - LEN_W'(1))); // R3
  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_en |=> $stable(bytes_left)); // R10
  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    data_done |-> (bytes_left == '0)); // R6
  AST_FAIL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    crc_bad |-> !(blk_done || data_done || active)); // R5
  AST_TMO_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    data_tmo |-> !(active || data_done || blk_done)); // R9
  AST_BLK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !blk_done); // R4
endmodule

bind xfer_len_tracker xlt_chk #(.LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xfer_en    (xfer_en),
  .byte_valid (byte_valid),
  .byte_ready (byte_ready),
  .bytes_left (bytes_left),
  .active     (active),
  .blk_done   (blk_done),
  .crc_bad    (crc_bad),
  .data_done  (data_done),
  .data_tmo   (data_tmo)
);

// File: tb/sim_xfer_len_tracker.sv
module sim_xfer_len_tracker;
  localparam int LEN_W = 25;
  localparam int TO_W  = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic [3:0]       cfg_blk_code = '0;
  logic [TO_W-1:0]  cfg_timeout = '0;
  logic             cfg_stream = 1'b0, cfg_to_card = 1'b0, xfer_en = 1'b0;
  logic             byte_valid = 1'b0, card_tick = 1'b0, card_go = 1'b0;
  logic             crc_valid = 1'b0, crc_pass = 1'b0;
  logic             byte_ready, active, blk_done, crc_bad, data_done, data_tmo;
  logic [LEN_W-1:0] bytes_left;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  xfer_len_tracker #(.LEN_W(LEN_W), .TO_W(TO_W)) u0 (.*);

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected below 150000", cyc);
      summary();
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int blk_bytes(input int code);
    return 1 << ((code > 14) ? 14 : code);
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // Full transfer; fail_blk selects a block whose CRC fails (-1 for none).
  task automatic run_xfer(input int len, input int code, input bit strm,
                          input bit to_card, input int fail_blk);
    int  left  = len;
    int  bsz   = blk_bytes(code);
    bit  first = 1'b1;
    int  blk   = 0;
    cfg_len = LEN_W'(len); cfg_blk_code = 4'(code);
    cfg_stream = strm; cfg_to_card = to_card; cfg_timeout = 32'd5;
    xfer_en = 1'b1;
    step();
    if (len == 0) begin
      chk("R6 zero length done", data_done, 1);
      chk("R6 zero length inactive", active, 0);
    end else begin
      chk("R1 loaded length", bytes_left, len);
      chk("R1 active", active, 1);
      while (left > 0) begin
        int nb;
        if (first && to_card) begin
          chk("R8 first block to card starts at once", byte_ready, 1);
        end else begin
          int w = $urandom_range(0, 3);
          for (int i = 0; i < w; i++) begin
            chk("R8 waits for card_go", byte_ready, 0);
            step();
          end
          card_go = 1'b1; step(); card_go = 1'b0;
        end
        first = 1'b0;
        nb = strm ? left : ((bsz < left) ? bsz : left);
        for (int i = 0; i < nb; i++) begin
          if (nb < 64) idle($urandom_range(0, 2));
          chk("R3 ready while moving", byte_ready, 1);
          byte_valid = 1'b1; step(); byte_valid = 1'b0;
          left--;
          if (nb < 64 || i == nb - 1) chk("R3 decrement", bytes_left, left);
        end
        if (strm) begin
          chk("R6 stream done", data_done, 1);
          chk("R7 stream no block event", blk_done, 0);
          chk("R7 stream ends", active, 0);
        end else begin
          chk("R4 ready drops at block end", byte_ready, 0);
          chk("R2 block boundary", active, 1);
          idle($urandom_range(0, 2));
          crc_valid = 1'b1; crc_pass = (blk != fail_blk);
          step();
          crc_valid = 1'b0;
          if (blk == fail_blk) begin
            chk("R5 crc_bad", crc_bad, 1);
            chk("R5 no data_done", data_done, 0);
            chk("R5 stops", active, 0);
            left = 0;
          end else begin
            chk("R4 blk_done", blk_done, 1);
            chk("R6 data_done timing", data_done, (left == 0) ? 1 : 0);
          end
          blk++;
        end
      end
    end
    xfer_en = 1'b0;
    step();
  endtask

  task automatic tick();
    card_tick = 1'b1; step(); card_tick = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    idle(2);
    chk("R11 reset bytes_left", bytes_left, 0);
    chk("R11 reset active", active, 0);
    chk("R11 reset ready", byte_ready, 0);
    chk("R11 reset events", {blk_done, crc_bad, data_done, data_tmo}, 0);
    rst_n = 1'b1;
    step();

    // Directed corners
    run_xfer(0, 3, 1'b0, 1'b0, -1);
    run_xfer(10, 2, 1'b0, 1'b1, -1);          // partial last block
    run_xfer(12, 2, 1'b0, 1'b0, 1);           // middle block fails
    run_xfer(600, 9, 1'b0, 1'b0, -1);
    run_xfer(16390, 15, 1'b0, 1'b1, -1);      // R2 code 15 clamps to 16384
    run_xfer(37, 1, 1'b1, 1'b0, -1);          // R7 stream

    // Constrained random
    for (int t = 0; t < 30; t++) begin
      int  len  = $urandom_range(1, 40);
      int  code = $urandom_range(0, 4);
      bit  strm = ($urandom_range(0, 3) == 0);
      int  fb   = ($urandom_range(0, 4) == 0) ? $urandom_range(0, 3) : -1;
      run_xfer(len, code, strm, 1'($urandom_range(0, 1)), fb);
    end

    // R9 timeout in first wait after three ticks
    cfg_len = 8; cfg_blk_code = 2; cfg_stream = 0; cfg_to_card = 0; cfg_timeout = 3;
    xfer_en = 1'b1; step();
    tick(); tick();
    chk("R9 no early timeout", data_tmo, 0);
    chk("R9 still waiting", active, 1);
    tick();
    chk("R9 timeout on third tick", data_tmo, 1);
    chk("R9 timeout ends", active, 0);
    xfer_en = 1'b0; step();

    // R9 reload between CRC wait and next block wait
    cfg_to_card = 1; xfer_en = 1'b1; step();
    for (int i = 0; i < 4; i++) begin
      byte_valid = 1'b1; tick(); byte_valid = 1'b0;
    end
    tick(); tick();
    chk("R9 crc wait no timeout", data_tmo, 0);
    crc_valid = 1'b1; crc_pass = 1'b1; step(); crc_valid = 1'b0;
    chk("R4 blk_done before reload", blk_done, 1);
    tick(); tick();
    chk("R9 reload between blocks", data_tmo, 0);
    chk("R9 second wait active", active, 1);
    tick();
    chk("R9 second wait times out", data_tmo, 1);
    xfer_en = 1'b0; step();

    // R9 zero timeout fires on first tick
    cfg_to_card = 0; cfg_timeout = 0; xfer_en = 1'b1; step();
    tick();
    chk("R9 zero timeout", data_tmo, 1);
    xfer_en = 1'b0; step();

    // R10 abort mid-block with the data path still offering bytes
    cfg_len = 20; cfg_blk_code = 4; cfg_to_card = 1; cfg_timeout = 5;
    xfer_en = 1'b1; step();
    for (int i = 0; i < 3; i++) begin
      byte_valid = 1'b1; step();
    end
    xfer_en = 1'b0; step();
    chk("R10 abort inactive", active, 0);
    chk("R10 frozen count", bytes_left, 17);
    idle(2);
    chk("R10 no accept after abort", bytes_left, 17);
    chk("R10 ready low", byte_ready, 0);
    chk("R10 no event", {blk_done, crc_bad, data_done, data_tmo}, 0);
    byte_valid = 1'b0;
    step();

    summary();
  end
endmodule